// File: doc/BRIEF.md
# Serial Debug Transport with Idle-Gated Bus Access

This block sits between a JTAG test access port and a debug module. The TAP controller drives it with the current instruction and the capture, shift and update strobes of the data-register path. The block picks the register that the instruction selects, loads it on capture, shifts it LSB first between `tdi` and `tdo`, and acts on it at update. Two of its registers matter for debug. The transport control word reports the version, the address width and the sticky error state. It also takes two clearing commands. The bus-access register turns a scanned word into a single-cycle read or write request to the debug module, and holds the result for the next scan.

Each access starts a countdown of required Run-Test/Idle cycles. If the debugger captures the bus-access register before the countdown runs out, the block returns a busy status. It also latches a sticky busy flag, and every later access is refused while that flag stands. A soft clear command drops only the flag. A hard clear command returns the whole transport to its reset state. The request/response port is combinational: the debug module answers within the update cycle.

Top module: `dbg_transport`

## Requirements
- R1: After reset, capturing the control word (instruction 5'h10) returns version 1 in bits 3:0, ABITS in bits 9:4, status 0 in bits 11:10, IDLE in bits 14:12 and zero elsewhere. Capturing the bus-access register (instruction 5'h11) returns all zeros.
- R2: The scan length is 32 bits for the identification code (instruction 5'h01, which captures the IDCODE parameter) and for the control word. It is ABITS+34 bits for the bus-access register. Bypass (5'h1f) and every unknown instruction select a 1-bit register that captures 0.
- R3: A bus-access update with op 1 (read) issues one request with write low and the scanned address (bits ABITS+33:34). If the module accepts, the held result carries the returned data in bits 33:2 and status 0 in bits 1:0.
- R4: An update with op 2 (write) issues one request carrying the scanned address and the data from bits 33:2. If the module accepts, the result holds the scanned address and data with status 0.
- R5: When the debug module rejects a read or a write, the result status is 2 and the data field keeps the scanned data.
- R6: Op 0 and op 3 issue no request. The result holds the scanned address and data with status 0.
- R7: Capturing the bus-access register while idle cycles are still owed loads the busy word (status 3, all other bits 0) and sets the sticky flag. While the flag is set, the control word shows 3 in bits 11:10.
- R8: While the sticky flag is set, every bus-access capture returns the busy word, and an update issues no request and leaves the held result unchanged.
- R9: Every accepted bus-access update reloads the owed-idle count with IDLE. The count drops by one on each clock with `in_idle` high and stops at zero. A capture after fewer than IDLE idle cycles is busy. A capture after IDLE idle cycles returns the result.
- R10: Updating the control word with bit 16 set clears only the sticky flag. The held result and the owed-idle count are unaffected.
- R11: Updating the control word with bit 17 set clears the sticky flag, the owed-idle count and the held result.
- R12: A request is only ever raised during an update with the bus-access instruction selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 5 | Current instruction from the TAP |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| in_idle | input | 1 | TAP is in Run-Test/Idle this cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of the selected register) |
| dm_req_valid | output | 1 | Single-cycle request to the debug module |
| dm_req_write | output | 1 | 1 for write, 0 for read |
| dm_req_addr | output | ABITS | Request address |
| dm_req_wdata | output | 32 | Write data |
| dm_rsp_ok | input | 1 | Debug module accepted the request (same cycle) |
| dm_rsp_rdata | input | 32 | Read data (same cycle) |

## Verification
The bound checker watches the owed-idle counter on every cycle. It checks the counter's bound, its reload after each accepted access and its decrement on idle cycles. It also checks that an early capture raises the sticky flag, that both clear commands act on the next cycle, and that no request appears outside a bus-access update or while the flag stands. Only the bench scenarios can show the data path end to end. That covers the captured words of each register and the read data and status placed in the result. It also covers the idle-count boundary, where IDLE-1 idle cycles give busy and IDLE give the result, and the result that survives a soft clear but not a hard one.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int IR_W       = 5;
    localparam int DATA_W     = 32;
    localparam int CTRL_LEN   = 32;
    localparam int IDLE_W     = 3;
    localparam int SOFT_BIT   = 16;
    localparam int HARD_BIT   = 17;

    localparam logic [IR_W-1:0] IR_IDCODE = 5'h01;
    localparam logic [IR_W-1:0] IR_CTRL   = 5'h10;
    localparam logic [IR_W-1:0] IR_DMI    = 5'h11;
    localparam logic [IR_W-1:0] IR_BYPASS = 5'h1f;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } dmi_op_e;

    localparam logic [1:0] ST_OK   = 2'd0;
    localparam logic [1:0] ST_FAIL = 2'd2;
    localparam logic [1:0] ST_BUSY = 2'd3;

    localparam logic [3:0] XPORT_VERSION = 4'd1;

    typedef struct packed {
        logic [14:0]       zero_hi;
        logic [IDLE_W-1:0] idle;
        logic [1:0]        stat;
        logic [5:0]        abits;
        logic [3:0]        version;
    } ctrl_word_t;

    function automatic ctrl_word_t make_ctrl(int abits, int idle, logic sticky);
        ctrl_word_t w;
        w.zero_hi = '0;
        w.idle    = IDLE_W'(idle);
        w.stat    = sticky ? ST_BUSY : ST_OK;
        w.abits   = 6'(abits);
        w.version = XPORT_VERSION;
        return w;
    endfunction

endpackage

// File: rtl/dtm_shift.sv
module dtm_shift #(
    parameter int W    = 41,
    parameter int LENW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [W-1:0]    load_val,
    input  logic            shift,
    input  logic [LENW-1:0] len,
    input  logic            tdi,
    output logic [W-1:0]    sr,
    output logic            tdo
);
    logic [W-1:0] sr_next;

    always_comb begin
        sr_next = sr >> 1;
        for (int j = 0; j < W; j++) begin
            if (j == int'(len) - 1) sr_next[j] = tdi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          sr <= '0;
        else if (capture) sr <= load_val;
        else if (shift)   sr <= sr_next;
    end

    assign tdo = sr[0];
endmodule

// File: rtl/dtm_busy.sv
module dtm_busy
    import dtm_pkg::*;
#(
    parameter int IDLE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_clr,
    input  logic              soft_clr,
    input  logic              probe,
    input  logic              reload,
    input  logic              tick,
    output logic              busy_now,
    output logic              sticky,
    output logic [IDLE_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || hard_clr)              sticky <= 1'b0;
        else if (soft_clr)                sticky <= 1'b0;
        else if (probe && busy_now)       sticky <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || hard_clr)              cnt <= '0;
        else if (reload)                  cnt <= IDLE_W'(IDLE);
        else if (tick && cnt != '0)       cnt <= cnt - 1'b1;
    end

    assign busy_now = sticky || (cnt != '0);
endmodule

// File: rtl/dtm_access.sv
module dtm_access
    import dtm_pkg::*;
#(
    parameter int ABITS = 7,
    localparam int DMI_W = ABITS + DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_clr,
    input  logic              do_update,
    input  logic [DMI_W-1:0]  scan,
    output logic              req_valid,
    output logic              req_write,
    output logic [ABITS-1:0]  req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_ok,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic [DMI_W-1:0]  result
);
    dmi_op_e           op;
    logic [DATA_W-1:0] data;
    logic [ABITS-1:0]  addr;
    logic              real_op;
    logic              ok;
    logic [DATA_W-1:0] data_out;

    assign op   = dmi_op_e'(scan[1:0]);
    assign data = scan[DATA_W+1:2];
    assign addr = scan[DMI_W-1:DATA_W+2];

    assign real_op   = (op == OP_READ) || (op == OP_WRITE);
    assign req_valid = do_update && real_op;
    assign req_write = (op == OP_WRITE);
    assign req_addr  = addr;
    assign req_wdata = data;

    assign ok       = real_op ? rsp_ok : 1'b1;
    assign data_out = (op == OP_READ && rsp_ok) ? rsp_rdata : data;

    always_ff @(posedge clk) begin
        if (rst || hard_clr) result <= '0;
        else if (do_update)  result <= {addr, data_out, (ok ? ST_OK : ST_FAIL)};
    end
endmodule

// File: rtl/dbg_transport.sv
module dbg_transport
    import dtm_pkg::*;
#(
    parameter int          ABITS  = 7,
    parameter int          IDLE   = 2,
    parameter logic [31:0] IDCODE = 32'h1000_0e31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              in_idle,
    input  logic              tdi,
    output logic              tdo,
    output logic              dm_req_valid,
    output logic              dm_req_write,
    output logic [ABITS-1:0]  dm_req_addr,
    output logic [DATA_W-1:0] dm_req_wdata,
    input  logic              dm_rsp_ok,
    input  logic [DATA_W-1:0] dm_rsp_rdata
);
    localparam int DMI_W = ABITS + DATA_W + 2;
    localparam int LENW  = $clog2(DMI_W + 1);

    logic [DMI_W-1:0]  shreg;
    logic [DMI_W-1:0]  cap_val;
    logic [LENW-1:0]   len;
    logic [DMI_W-1:0]  result;
    logic              busy_now;
    logic              busy_sticky;
    logic [IDLE_W-1:0] idle_cnt;
    logic              sel_dmi;
    logic              sel_ctrl;
    logic              hard_clr;
    logic              soft_clr;
    logic              dmi_update;
    ctrl_word_t        ctrl_now;

    assign sel_dmi  = (ir == IR_DMI);
    assign sel_ctrl = (ir == IR_CTRL);

    assign hard_clr   = update_dr && sel_ctrl && shreg[HARD_BIT];
    assign soft_clr   = update_dr && sel_ctrl && shreg[SOFT_BIT];
    assign dmi_update = update_dr && sel_dmi && !busy_sticky;

    assign ctrl_now = make_ctrl(ABITS, IDLE, busy_sticky);

    always_comb begin
        cap_val = '0;
        len     = LENW'(1);
        case (ir)
            IR_IDCODE: begin
                cap_val = DMI_W'(IDCODE);
                len     = LENW'(32);
            end
            IR_CTRL: begin
                cap_val = DMI_W'(ctrl_now);
                len     = LENW'(CTRL_LEN);
            end
            IR_DMI: begin
                cap_val = busy_now ? DMI_W'(ST_BUSY) : result;
                len     = LENW'(DMI_W);
            end
            default: begin
                cap_val = '0;
                len     = LENW'(1);
            end
        endcase
    end

    dtm_shift #(.W(DMI_W), .LENW(LENW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture_dr),
        .load_val (cap_val),
        .shift    (shift_dr),
        .len      (len),
        .tdi      (tdi),
        .sr       (shreg),
        .tdo      (tdo)
    );

    dtm_busy #(.IDLE(IDLE)) u_busy (
        .clk      (clk),
        .rst      (rst),
        .hard_clr (hard_clr),
        .soft_clr (soft_clr),
        .probe    (capture_dr && sel_dmi),
        .reload   (dmi_update),
        .tick     (in_idle),
        .busy_now (busy_now),
        .sticky   (busy_sticky),
        .cnt      (idle_cnt)
    );

    dtm_access #(.ABITS(ABITS)) u_access (
        .clk       (clk),
        .rst       (rst),
        .hard_clr  (hard_clr),
        .do_update (dmi_update),
        .scan      (shreg),
        .req_valid (dm_req_valid),
        .req_write (dm_req_write),
        .req_addr  (dm_req_addr),
        .req_wdata (dm_req_wdata),
        .rsp_ok    (dm_rsp_ok),
        .rsp_rdata (dm_rsp_rdata),
        .result    (result)
    );
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker
    import dtm_pkg::*;
#(
    parameter int ABITS = 7,
    parameter int IDLE  = 2,
    localparam int DMI_W = ABITS + DATA_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic [IR_W-1:0]   ir,
    input logic              capture_dr,
    input logic              update_dr,
    input logic              in_idle,
    input logic              dm_req_valid,
    input logic              sticky,
    input logic [IDLE_W-1:0] cnt,
    input logic [DMI_W-1:0]  shreg
);
    a_r12_req_in_dmi_update: assert property (@(posedge clk) disable iff (rst)
        dm_req_valid |-> (update_dr && ir == IR_DMI));

    a_r8_no_req_while_sticky: assert property (@(posedge clk) disable iff (rst)
        (sticky && update_dr) |-> !dm_req_valid);

    a_r7_early_capture_sticks: assert property (@(posedge clk) disable iff (rst)
        (capture_dr && ir == IR_DMI && cnt != '0) |=> sticky);

    a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= IDLE_W'(IDLE));

    a_r9_count_reload: assert property (@(posedge clk) disable iff (rst)
        (update_dr && ir == IR_DMI && !sticky) |=> (cnt == IDLE_W'(IDLE)));

    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (in_idle && !update_dr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    a_r10_soft_clear: assert property (@(posedge clk) disable iff (rst)
        (update_dr && ir == IR_CTRL && shreg[SOFT_BIT]) |=> !sticky);

    a_r11_hard_clear: assert property (@(posedge clk) disable iff (rst)
        (update_dr && ir == IR_CTRL && shreg[HARD_BIT]) |=> (!sticky && cnt == '0));
endmodule

bind dbg_transport dtm_checker #(.ABITS(ABITS), .IDLE(IDLE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ir           (ir),
    .capture_dr   (capture_dr),
    .update_dr    (update_dr),
    .in_idle      (in_idle),
    .dm_req_valid (dm_req_valid),
    .sticky       (busy_sticky),
    .cnt          (idle_cnt),
    .shreg        (shreg)
);

// File: tb/dbg_transport_tb.sv
module dbg_transport_tb;
    localparam int ABITS = 7;
    localparam int IDLE  = 2;
    localparam logic [31:0] IDC = 32'h1000_0e31;
    localparam int DW = ABITS + 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] ir = 5'h1f;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, in_idle = 0, tdi = 0;
    logic tdo;
    logic dm_req_valid, dm_req_write, dm_rsp_ok;
    logic [ABITS-1:0] dm_req_addr;
    logic [31:0] dm_req_wdata, dm_rsp_rdata;
    logic [31:0] mem [64];

    int checks = 0, errors = 0, cycles = 0;
    logic req_seen, req_w;
    logic [ABITS-1:0] req_a;
    logic [31:0] req_d;
    logic [DW-1:0] dout;

    always #5 clk = ~clk;

    dbg_transport #(.ABITS(ABITS), .IDLE(IDLE), .IDCODE(IDC)) u_dut (
        .clk(clk), .rst(rst), .ir(ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .in_idle(in_idle), .tdi(tdi), .tdo(tdo),
        .dm_req_valid(dm_req_valid), .dm_req_write(dm_req_write),
        .dm_req_addr(dm_req_addr), .dm_req_wdata(dm_req_wdata),
        .dm_rsp_ok(dm_rsp_ok), .dm_rsp_rdata(dm_rsp_rdata)
    );

    // Debug-module model: accepts addresses below 64
    assign dm_rsp_ok    = (dm_req_addr < 7'd64);
    assign dm_rsp_rdata = mem[dm_req_addr[5:0]];
    always @(posedge clk)
        if (dm_req_valid && dm_req_write && dm_rsp_ok) mem[dm_req_addr[5:0]] <= dm_req_wdata;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic scan(input logic [4:0] sel, input int len, input logic [DW-1:0] din);
        @(negedge clk);
        ir = sel; capture_dr = 1;
        @(negedge clk);
        capture_dr = 0;
        dout = '0;
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            shift_dr = 1; tdi = din[i];
            @(negedge clk);
        end
        shift_dr = 0; tdi = 0; update_dr = 1;
        #1;
        req_seen = dm_req_valid; req_w = dm_req_write; req_a = dm_req_addr; req_d = dm_req_wdata;
        @(negedge clk);
        update_dr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_idle = 1;
            @(negedge clk);
        end
        in_idle = 0;
    endtask

    function automatic logic [DW-1:0] dmi(logic [6:0] a, logic [31:0] d, logic [1:0] op);
        return {a, d, op};
    endfunction

    // {op, addr, data, exp_status, exp_data, exp_req}
    localparam logic [75:0] TBL [8] = '{
        {2'd2, 7'h03, 32'hDEADBEEF, 2'd0, 32'hDEADBEEF, 1'b1},
        {2'd1, 7'h03, 32'h00000000, 2'd0, 32'hDEADBEEF, 1'b1},
        {2'd1, 7'h05, 32'h00000000, 2'd0, 32'hA5000005, 1'b1},
        {2'd2, 7'h50, 32'h12345678, 2'd2, 32'h12345678, 1'b1},
        {2'd1, 7'h41, 32'h0000FFFF, 2'd2, 32'h0000FFFF, 1'b1},
        {2'd0, 7'h02, 32'hCAFE0000, 2'd0, 32'hCAFE0000, 1'b0},
        {2'd3, 7'h04, 32'h0BADF00D, 2'd0, 32'h0BADF00D, 1'b0},
        {2'd1, 7'h04, 32'h00000000, 2'd0, 32'hA5000004, 1'b1}
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ctrl_exp;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA5000000 + i;
        ctrl_exp = (32'(IDLE) << 12) | (32'(ABITS) << 4) | 32'd1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        scan(5'h10, 32, '0);
        check("R1 ctrl after reset", 64'(dout[31:0]), 64'(ctrl_exp));
        scan(5'h11, DW, '0);
        check("R1 dmi after reset", 64'(dout), 64'd0);
        idle(IDLE);

        // R2 lengths and capture values
        scan(5'h01, 32, '0);
        check("R2 idcode", 64'(dout[31:0]), 64'(IDC));
        scan(5'h1f, 1, 41'd1);
        check("R2 bypass captures 0", 64'(dout[0]), 64'd0);
        scan(5'h05, 1, 41'd1);
        check("R2 unknown ir bypass", 64'(dout[0]), 64'd0);
        check("R12 no request off DMI", 64'(req_seen), 64'd0);

        // R3 R4 R5 R6 table
        foreach (TBL[k]) begin
            logic [1:0] op; logic [6:0] a; logic [31:0] d, ed; logic [1:0] es; logic er;
            {op, a, d, es, ed, er} = TBL[k];
            scan(5'h11, DW, dmi(a, d, op));
            check($sformatf("R3/R4/R6 request issued row %0d", k), 64'(req_seen), 64'(er));
            if (er) check($sformatf("R3/R4 request fields row %0d", k),
                          {req_w, req_a, req_d}, {op == 2'd2, a, (op == 2'd2) ? d : d});
            idle(IDLE);
            scan(5'h11, DW, dmi(7'h00, 32'h0, 2'd0));
            check($sformatf("R5 result row %0d", k), 64'(dout), 64'(dmi(a, ed, es)));
            idle(IDLE);
        end

        // R7 early capture
        scan(5'h11, DW, dmi(7'h03, 32'h0, 2'd1));
        scan(5'h11, DW, dmi(7'h06, 32'h1, 2'd2));
        check("R7 busy captured", 64'(dout), 64'd3);
        check("R8 no request after busy capture", 64'(req_seen), 64'd0);
        scan(5'h10, 32, '0);
        check("R7 ctrl status busy", 64'(dout[11:10]), 64'd3);
        idle(IDLE);
        scan(5'h11, DW, dmi(7'h06, 32'h1, 2'd2));
        check("R8 sticky busy after idle", 64'(dout), 64'd3);
        check("R8 sticky blocks request", 64'(req_seen), 64'd0);
        scan(5'h10, 32, 41'(1) << 16);
        idle(IDLE);
        scan(5'h11, DW, dmi(7'h02, 32'h0, 2'd0));
        check("R10 result kept after soft clear", 64'(dout), 64'(dmi(7'h03, 32'hDEADBEEF, 2'd0)));
        check("R8 memory untouched", 64'(mem[6]), 64'(32'hA5000006));

        // R9 idle-count boundary
        idle(IDLE - 1);
        scan(5'h11, DW, dmi(7'h09, 32'h0, 2'd0));
        check("R9 one idle short is busy", 64'(dout), 64'd3);
        scan(5'h10, 32, 41'(1) << 16);
        idle(IDLE + 3);
        scan(5'h11, DW, dmi(7'h00, 32'h0, 2'd0));
        check("R9 enough idle returns result", 64'(dout), 64'(dmi(7'h02, 32'h0, 2'd0)));
        idle(IDLE);

        // R11 hard clear
        scan(5'h11, DW, dmi(7'h03, 32'h0, 2'd1));
        scan(5'h10, 32, 41'(1) << 17);
        scan(5'h10, 32, '0);
        check("R11 ctrl after hard clear", 64'(dout[31:0]), 64'(ctrl_exp));
        scan(5'h11, DW, '0);
        check("R11 result and count cleared", 64'(dout), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule